// File: doc/BRIEF.md
# Tagged Linear-Chain 8-Point FFT

This block computes an 8-point radix-2 decimation-in-frequency FFT on a stream of complex samples. Seven butterfly elements sit in a single line. The first element does the first stage. The next two split the second stage by index half. The last four each do one third-stage butterfly. The only links are between an element and its successor. Every datum travels with a tag that holds the number of the element that needs it and a bit that says whether it is the upper or the lower butterfly input. The tag of an input sample comes from its sample index. The tag of a result comes from the stage of the element that produced it and the flow-graph node that result fills. On every arriving datum, each element either keeps it as an operand or passes it on to its neighbour.

An element holds at most one upper operand and one lower operand. It fires as soon as it has both. Its two results go into a short local queue. Traffic being passed through has priority on the outgoing link, and queued results use the free cycles. The last link leaves the block as the output stream. Each output carries the frequency bin it holds. Bins leave in the order the chain produces them and are not sorted. Each stage halves its results, so the output is the DFT divided by eight. A new frame may begin once the previous frame has fully drained, which is at most 64 cycles after its last sample.

Top module: `tagged_fft8`

## Requirements
- R1: For inputs whose real and imaginary parts lie within ±2^(DATA_W-2), each output value equals the exact DFT of the frame divided by 8, to within ±6 LSB in both real and imaginary parts.
- R2: Each frame produces exactly 8 output beats. outBin carries the frequency bin (0..7), and each bin appears exactly once per frame.
- R3: The input is tagged from inIdx. Bit 2 of inIdx marks a sample as the lower operand of the first-stage pair (k, k+4). Both the upper-first order 0,4,2,6,1,5,3,7 and the lower-first order 4,0,6,2,5,1,7,3 are accepted and give the same result.
- R4: A datum whose tag names a different element leaves that element on the very next cycle, with its tag unchanged.
- R5: Data only move toward higher-numbered elements. Every datum on the link after element p is tagged either for an element above p or for exit (destination 0).
- R6: Only finished results, tagged with destination 0, reach the output link.
- R7: The last output beat of a frame appears within 64 cycles after the frame's last input sample.
- R8: After reset, and while no input is presented, outValid stays low.
- R9: The total number of output beats never exceeds the total number of input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample present this cycle |
| inIdx | input | 3 | Time index of the input sample within its frame |
| inRe | input | DATA_W | Real part of the input sample, signed |
| inIm | input | DATA_W | Imaginary part of the input sample, signed |
| outValid | output | 1 | Output bin value present this cycle |
| outBin | output | 3 | Frequency bin of the output value |
| outRe | output | DATA_W | Real part of the bin value, scaled by 1/8 |
| outIm | output | DATA_W | Imaginary part of the bin value, scaled by 1/8 |

## Verification
The bench builds the block with DATA_W = 16 and TW_FRAC = 14. At that width, input samples up to ±16000 pass through all three halving stages without wrapping. The 14-bit twiddles are exact enough that a ±6 LSB tolerance separates truncation noise from a real datapath or routing error. This covers impulse, constant, single-tone and full-range random frames in both accepted input orders, and so exercises every twiddle value and every tag-routing path through the chain.

// File: rtl/tsfft_pkg.sv
package tsfft_pkg;
  localparam int NPE         = 7;
  localparam int ID_W        = 3;
  localparam int IDX_W       = 3;
  localparam int QUEUE_DEPTH = 4;
  localparam int QPTR_W      = $clog2(QUEUE_DEPTH);

  typedef struct packed {
    logic [ID_W-1:0] dest;   // 0 = leave the chain
    logic            lower;  // 1 = lower butterfly operand
  } tag_t;

  typedef struct packed {
    logic              takeUp;
    logic              takeLo;
    logic              fire;
    logic              inIsUp;
    logic              fwd;
    logic              pop;
    logic [QPTR_W-1:0] wrPtr;
    logic [QPTR_W-1:0] rdPtr;
  } peStrobe_t;

  function automatic int peStage(input int id);
    if (id == 1) return 0;
    if (id <= 3) return 1;
    return 2;
  endfunction

  // Destination of a result produced at a given stage for flow-graph node idx.
  function automatic tag_t nextTag(input int stage, input logic [IDX_W-1:0] idx);
    tag_t t;
    if (stage == 0) begin
      t.dest  = 3'd2 + {2'b00, idx[2]};
      t.lower = idx[1];
    end else if (stage == 1) begin
      t.dest  = 3'd4 + {1'b0, idx[2:1]};
      t.lower = idx[0];
    end else begin
      t.dest  = 3'd0;
      t.lower = 1'b0;
    end
    return t;
  endfunction

  // Exponent k of W8^k for the butterfly whose upper node is idx.
  function automatic logic [1:0] twExp(input int stage, input logic [IDX_W-1:0] idx);
    if (stage == 0) return idx[1:0];
    if (stage == 1) return {idx[0], 1'b0};
    return 2'd0;
  endfunction
endpackage

// File: rtl/tsfft_pe_ctrl.sv
module tsfft_pe_ctrl import tsfft_pkg::*; #(
  parameter int PE_ID = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  tag_t      inTag,
  output peStrobe_t strobe,
  output logic      outValid
);
  localparam int CNT_W = QPTR_W + 1;

  logic              upV, loV;
  logic [CNT_W-1:0]  qCount;
  logic [QPTR_W-1:0] wrPtr, rdPtr;
  logic              hit, fire, takeUp, takeLo, fwd, pop;

  always_comb begin
    hit    = inValid && (inTag.dest == ID_W'(PE_ID));
    fire   = hit && (inTag.lower ? upV : loV);
    takeUp = hit && !inTag.lower && !loV && !upV;
    takeLo = hit &&  inTag.lower && !upV && !loV;
    fwd    = inValid && !hit;
    pop    = !fwd && (qCount != '0);

    strobe.takeUp = takeUp;
    strobe.takeLo = takeLo;
    strobe.fire   = fire;
    strobe.inIsUp = !inTag.lower;
    strobe.fwd    = fwd;
    strobe.pop    = pop;
    strobe.wrPtr  = wrPtr;
    strobe.rdPtr  = rdPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upV      <= 1'b0;
      loV      <= 1'b0;
      qCount   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      outValid <= 1'b0;
    end else begin
      if (takeUp) upV <= 1'b1;
      else if (fire && inTag.lower) upV <= 1'b0;
      if (takeLo) loV <= 1'b1;
      else if (fire && !inTag.lower) loV <= 1'b0;
      qCount   <= qCount - CNT_W'(pop) + (fire ? CNT_W'(2) : CNT_W'(0));
      wrPtr    <= wrPtr + (fire ? QPTR_W'(2) : QPTR_W'(0));
      rdPtr    <= rdPtr + QPTR_W'(pop);
      outValid <= fwd || pop;
    end
  end
endmodule

// File: rtl/tsfft_pe_dp.sv
module tsfft_pe_dp import tsfft_pkg::*; #(
  parameter int PE_ID   = 1,
  parameter int DATA_W  = 16,
  parameter int TW_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  peStrobe_t                strobe,
  input  tag_t                     inTag,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output tag_t                     outTag,
  output logic [IDX_W-1:0]         outIdx,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  localparam int STAGE  = peStage(PE_ID);
  localparam logic [IDX_W-1:0] SPAN_BIT = IDX_W'(4 >> STAGE);
  localparam int TW_W   = TW_FRAC + 2;
  localparam int SUM_W  = DATA_W + 1;
  localparam int PROD_W = SUM_W + TW_W + 1;
  localparam longint ONE_L = longint'(1) << TW_FRAC;
  localparam longint C45_L = (longint'(46341) << TW_FRAC) >> 16;
  localparam logic signed [TW_W-1:0] TW_ONE = TW_W'(ONE_L);
  localparam logic signed [TW_W-1:0] TW_C45 = TW_W'(C45_L);

  logic signed [DATA_W-1:0] upRe, upIm, loRe, loIm;
  logic [IDX_W-1:0]         upIdx;
  logic signed [DATA_W-1:0] qRe [QUEUE_DEPTH];
  logic signed [DATA_W-1:0] qIm [QUEUE_DEPTH];
  logic [IDX_W-1:0]         qIdx[QUEUE_DEPTH];
  tag_t                     qTag[QUEUE_DEPTH];

  logic signed [DATA_W-1:0] effUpRe, effUpIm, effLoRe, effLoIm;
  logic [IDX_W-1:0]         effUpIdx, loResIdx;
  logic signed [SUM_W-1:0]  sRe, sIm, dRe, dIm;
  logic signed [TW_W-1:0]   twRe, twIm;
  logic signed [PROD_W-1:0] pRe, pIm;
  logic signed [DATA_W-1:0] upResRe, upResIm, loResRe, loResIm;
  logic [QPTR_W-1:0]        wrNext;

  always_comb begin
    effUpRe  = strobe.inIsUp ? inRe  : upRe;
    effUpIm  = strobe.inIsUp ? inIm  : upIm;
    effLoRe  = strobe.inIsUp ? loRe  : inRe;
    effLoIm  = strobe.inIsUp ? loIm  : inIm;
    effUpIdx = strobe.inIsUp ? inIdx : upIdx;
    loResIdx = effUpIdx | SPAN_BIT;

    case (twExp(STAGE, effUpIdx))
      2'd0:    begin twRe = TW_ONE;  twIm = '0;      end
      2'd1:    begin twRe = TW_C45;  twIm = -TW_C45; end
      2'd2:    begin twRe = '0;      twIm = -TW_ONE; end
      default: begin twRe = -TW_C45; twIm = -TW_C45; end
    endcase

    sRe = {effUpRe[DATA_W-1], effUpRe} + {effLoRe[DATA_W-1], effLoRe};
    sIm = {effUpIm[DATA_W-1], effUpIm} + {effLoIm[DATA_W-1], effLoIm};
    dRe = {effUpRe[DATA_W-1], effUpRe} - {effLoRe[DATA_W-1], effLoRe};
    dIm = {effUpIm[DATA_W-1], effUpIm} - {effLoIm[DATA_W-1], effLoIm};
    pRe = PROD_W'(dRe) * PROD_W'(twRe) - PROD_W'(dIm) * PROD_W'(twIm);
    pIm = PROD_W'(dRe) * PROD_W'(twIm) + PROD_W'(dIm) * PROD_W'(twRe);

    upResRe = sRe[DATA_W:1];
    upResIm = sIm[DATA_W:1];
    loResRe = pRe[TW_FRAC+1 +: DATA_W];
    loResIm = pIm[TW_FRAC+1 +: DATA_W];
    wrNext  = strobe.wrPtr + QPTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upRe <= '0; upIm <= '0; loRe <= '0; loIm <= '0; upIdx <= '0;
      outTag <= '0; outIdx <= '0; outRe <= '0; outIm <= '0;
      for (int i = 0; i < QUEUE_DEPTH; i++) begin
        qRe[i] <= '0; qIm[i] <= '0; qIdx[i] <= '0; qTag[i] <= '0;
      end
    end else begin
      if (strobe.takeUp) begin
        upRe <= inRe; upIm <= inIm; upIdx <= inIdx;
      end
      if (strobe.takeLo) begin
        loRe <= inRe; loIm <= inIm;
      end
      if (strobe.fire) begin
        qRe[strobe.wrPtr]  <= upResRe;
        qIm[strobe.wrPtr]  <= upResIm;
        qIdx[strobe.wrPtr] <= effUpIdx;
        qTag[strobe.wrPtr] <= nextTag(STAGE, effUpIdx);
        qRe[wrNext]        <= loResRe;
        qIm[wrNext]        <= loResIm;
        qIdx[wrNext]       <= loResIdx;
        qTag[wrNext]       <= nextTag(STAGE, loResIdx);
      end
      if (strobe.fwd) begin
        outTag <= inTag; outIdx <= inIdx; outRe <= inRe; outIm <= inIm;
      end else if (strobe.pop) begin
        outTag <= qTag[strobe.rdPtr];
        outIdx <= qIdx[strobe.rdPtr];
        outRe  <= qRe[strobe.rdPtr];
        outIm  <= qIm[strobe.rdPtr];
      end
    end
  end
endmodule

// File: rtl/tsfft_pe.sv
module tsfft_pe import tsfft_pkg::*; #(
  parameter int PE_ID   = 1,
  parameter int DATA_W  = 16,
  parameter int TW_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  tag_t                     inTag,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output tag_t                     outTag,
  output logic [IDX_W-1:0]         outIdx,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  peStrobe_t strobe;

  tsfft_pe_ctrl #(.PE_ID(PE_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
    .strobe(strobe), .outValid(outValid)
  );

  tsfft_pe_dp #(.PE_ID(PE_ID), .DATA_W(DATA_W), .TW_FRAC(TW_FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inTag(inTag), .inIdx(inIdx),
    .inRe(inRe), .inIm(inIm), .outTag(outTag), .outIdx(outIdx),
    .outRe(outRe), .outIm(outIm)
  );
endmodule

// File: rtl/tagged_fft8.sv
module tagged_fft8 import tsfft_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int TW_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output logic [IDX_W-1:0]         outBin,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  logic                     linkV   [0:NPE];
  tag_t                     linkTag [0:NPE];
  logic [IDX_W-1:0]         linkIdx [0:NPE];
  logic signed [DATA_W-1:0] linkRe  [0:NPE];
  logic signed [DATA_W-1:0] linkIm  [0:NPE];

  // Input samples are tagged for element 1; index bit 2 marks the lower half.
  assign linkV[0]         = inValid;
  assign linkTag[0].dest  = ID_W'(1);
  assign linkTag[0].lower = inIdx[2];
  assign linkIdx[0]       = inIdx;
  assign linkRe[0]        = inRe;
  assign linkIm[0]        = inIm;

  for (genvar p = 1; p <= NPE; p++) begin : g_pe
    tsfft_pe #(.PE_ID(p), .DATA_W(DATA_W), .TW_FRAC(TW_FRAC)) u_pe (
      .clk(clk), .rstN(rstN),
      .inValid(linkV[p-1]), .inTag(linkTag[p-1]), .inIdx(linkIdx[p-1]),
      .inRe(linkRe[p-1]), .inIm(linkIm[p-1]),
      .outValid(linkV[p]), .outTag(linkTag[p]), .outIdx(linkIdx[p]),
      .outRe(linkRe[p]), .outIm(linkIm[p])
    );
  end

  assign outValid = linkV[NPE];
  assign outBin   = {linkIdx[NPE][0], linkIdx[NPE][1], linkIdx[NPE][2]};
  assign outRe    = linkRe[NPE];
  assign outIm    = linkIm[NPE];
endmodule

// File: rtl/tsfft_chk.sv
module tsfft_chk import tsfft_pkg::*; (
  input logic clk,
  input logic rstN,
  input logic linkV   [0:NPE],
  input tag_t linkTag [0:NPE]
);
  logic [31:0] inCnt, outCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt  <= '0;
      outCnt <= '0;
    end else begin
      inCnt  <= inCnt + 32'(linkV[0]);
      outCnt <= outCnt + 32'(linkV[NPE]);
    end
  end

  for (genvar p = 1; p <= NPE; p++) begin : g_hop
    assert_fwd_hop_R4: assert property (@(posedge clk) disable iff (!rstN)
      (linkV[p-1] && linkTag[p-1].dest != ID_W'(p)) |=>
        (linkV[p] && linkTag[p] == $past(linkTag[p-1])));

    assert_dest_ahead_R5: assert property (@(posedge clk) disable iff (!rstN)
      linkV[p] |-> (linkTag[p].dest == '0 || linkTag[p].dest > ID_W'(p)));
  end

  assert_exit_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    linkV[NPE] |-> linkTag[NPE].dest == '0);

  assert_no_excess_R9: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= inCnt);
endmodule

bind tagged_fft8 tsfft_chk u_chk (
  .clk(clk), .rstN(rstN), .linkV(linkV), .linkTag(linkTag)
);

// File: tb/tagged_fft8_bench.sv
`timescale 1ns/1ps
module tagged_fft8_bench;
  localparam int DW  = 16;
  localparam int TOL = 6;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic [2:0]           inIdx = '0;
  logic signed [DW-1:0] inRe = '0, inIm = '0;
  logic                 outValid;
  logic [2:0]           outBin;
  logic signed [DW-1:0] outRe, outIm;

  int nChecks = 0, nFails = 0;
  int beats = 0, totalIn = 0, totalOut = 0;
  int gotCnt[8];
  int gotRe[8];
  int gotIm[8];

  always #4 clk = ~clk;

  tagged_fft8 #(.DATA_W(DW), .TW_FRAC(14)) u_tagged_fft8 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIdx(inIdx), .inRe(inRe),
    .inIm(inIm), .outValid(outValid), .outBin(outBin), .outRe(outRe), .outIm(outIm)
  );

  always @(negedge clk) begin
    if (rstN && outValid) begin
      beats++;
      totalOut++;
      gotCnt[outBin]++;
      gotRe[outBin] = outRe;
      gotIm[outBin] = outIm;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic runFrame(input string label, input int xr[8], input int xi[8],
                          input bit lowerFirst);
    int upOrd[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    int loOrd[8] = '{4, 0, 6, 2, 5, 1, 7, 3};
    int waited = 0;
    beats = 0;
    for (int k = 0; k < 8; k++) gotCnt[k] = 0;
    for (int i = 0; i < 8; i++) begin
      int n = lowerFirst ? loOrd[i] : upOrd[i];
      @(negedge clk);
      inValid = 1'b1;
      inIdx   = 3'(n);
      inRe    = DW'(xr[n]);
      inIm    = DW'(xi[n]);
      totalIn++;
    end
    @(negedge clk);
    inValid = 1'b0;
    while (beats < 8 && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    // R7: frame drained within 64 cycles of the last sample
    check(beats == 8, "R7", {label, " beats within latency bound"}, beats, 8);
    repeat (16) @(negedge clk);
    check(beats == 8, "R2", {label, " beats per frame"}, beats, 8);
    for (int k = 0; k < 8; k++) begin
      real er = 0.0, ei = 0.0;
      int expRe, expIm;
      for (int n = 0; n < 8; n++) begin
        real th = 2.0 * 3.14159265358979 * n * k / 8.0;
        er += xr[n] * $cos(th) + xi[n] * $sin(th);
        ei += xi[n] * $cos(th) - xr[n] * $sin(th);
      end
      expRe = $rtoi(er / 8.0 + ((er >= 0.0) ? 0.5 : -0.5));
      expIm = $rtoi(ei / 8.0 + ((ei >= 0.0) ? 0.5 : -0.5));
      check(gotCnt[k] == 1, "R2", $sformatf("%s bin %0d count", label, k), gotCnt[k], 1);
      // R1 value; R3 order; R4 R5 R6 routing is observed through these values
      check(absI(gotRe[k] - expRe) <= TOL, lowerFirst ? "R1 R3" : "R1 R4 R5 R6",
            $sformatf("%s bin %0d real", label, k), gotRe[k], expRe);
      check(absI(gotIm[k] - expIm) <= TOL, lowerFirst ? "R1 R3" : "R1 R4 R5 R6",
            $sformatf("%s bin %0d imag", label, k), gotIm[k], expIm);
    end
    check(totalOut <= totalIn, "R9", {label, " output beats vs inputs"}, totalOut, totalIn);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid during reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(totalOut == 0, "R8", "beats while idle after reset", totalOut, 0);
  endtask

  task automatic testImpulse();
    int xr[8], xi[8];
    for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 8000;
    runFrame("impulse", xr, xi, 1'b0);
  endtask

  task automatic testConstant();
    int xr[8], xi[8];
    for (int n = 0; n < 8; n++) begin xr[n] = 6400; xi[n] = -3200; end
    runFrame("constant", xr, xi, 1'b0);
  endtask

  task automatic testTone();
    int xr[8], xi[8];
    for (int n = 0; n < 8; n++) begin
      xr[n] = $rtoi(12000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 8.0));
      xi[n] = $rtoi(12000.0 * $sin(2.0 * 3.14159265358979 * 3 * n / 8.0));
    end
    runFrame("tone3", xr, xi, 1'b0);
  endtask

  task automatic testRandom(input int count, input bit lowerFirst);
    for (int f = 0; f < count; f++) begin
      int xr[8], xi[8];
      for (int n = 0; n < 8; n++) begin
        xr[n] = int'($urandom_range(32000)) - 16000;
        xi[n] = int'($urandom_range(32000)) - 16000;
      end
      runFrame(lowerFirst ? "random_lower_first" : "random", xr, xi, lowerFirst);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", beats, 8);
    finishRun();
  end

  initial begin
    testReset();
    testImpulse();
    testConstant();
    testTone();
    testRandom(4, 1'b0);
    testRandom(3, 1'b1);
    finishRun();
  end
endmodule